// File: doc/BRIEF.md
# I2C Command-Stream Sequencer

This block turns a stream of 10-bit transmit-queue entries into byte-level operations for an I2C bit engine. Each entry carries a data byte in its low eight bits and two control flags above it. One flag makes the entry an address that opens a transfer with a start condition. If the bus is already held, that start is a repeated start. The other flag closes the transfer with a stop once the entry's byte has been handled. Unflagged entries are plain data bytes written on a held bus.

When an address has its read bit set, the next entry gives the number of bytes to receive. The block then reads that many bytes, acknowledging every byte but the last, and hands each byte out on a one-cycle strobe. It pulses events for a transmit error (a missing acknowledge, or completion of a read), for arbitration loss, and for the bus going idle after a stop. A status level shows that the bus is held.

Line timing stays in the bit engine. This block talks to it through a request/done handshake with four operations. On any failure it drops the rest of the command and skips queue entries until the next address entry.

Top module: `i2c_cmd_seq`

## Requirements
- R1: With the bus idle, an entry with bit 8 set is popped and produces a start operation followed by a byte write of its low byte. `bus_busy` becomes 1 once the start completes.
- R2: An entry with bit 8 set that arrives while the bus is held produces another start operation (a repeated start). `bus_busy` stays 1 and no bus-idle event occurs in between.
- R3: An entry with bit 8 clear that arrives while the bus is held is written as one data byte.
- R4: An entry with bit 9 set is followed by a stop operation after its byte has been handled. When the stop completes, `bus_busy` drops to 0 and `ev_bus_idle` pulses for one cycle.
- R5: An entry with both bit 8 and bit 9 set produces exactly start, address write, stop.
- R6: After an address whose bit 0 is 1 has been acknowledged, the next entry's low byte is the receive count N, and that entry's bit 9 decides whether a stop follows the N reads.
- R7: During a read, `eng_nack` is 0 on each of the first N-1 read operations and 1 on the last. Each received byte appears on `rx_data` with a one-cycle `rx_valid`.
- R8: `ev_tx_err` pulses in the same cycle as the `rx_valid` of the final byte of a read.
- R9: A missing acknowledge (`eng_ack`=0) on an address or data write pulses `ev_tx_err`, issues a stop and returns to idle. Later entries with bit 8 clear are then discarded.
- R10: `eng_arb_lost` on completion of any operation pulses `ev_arb_lost` and clears `bus_busy` without issuing a stop. The sequencer returns to idle.
- R11: While the bus is held and the queue is empty (waiting for a data entry or a receive count), `scl_hold` is 1 and no engine request is raised.
- R12: Entries with bit 8 clear that arrive while the bus is idle are popped and produce no engine operation.
- R13: `eng_op` codes are 0 start, 1 stop, 2 write byte, 3 read byte. A raised `eng_req` keeps its operation and write byte until `eng_done`, and `cmd_pop` is raised only with `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Queue head entry is present |
| cmd_data | input | 10 | Queue head entry: byte, bit 8 start flag, bit 9 stop flag |
| cmd_pop | output | 1 | Consume the queue head this cycle |
| eng_req | output | 1 | Operation request to the bit engine |
| eng_op | output | 2 | Requested operation code |
| eng_wdata | output | 8 | Byte for a write operation |
| eng_nack | output | 1 | Read operation answers with not-acknowledge |
| eng_done | input | 1 | Engine finished the requested operation |
| eng_ack | input | 1 | Write was acknowledged by the target (valid with done) |
| eng_arb_lost | input | 1 | Arbitration lost during the operation (valid with done) |
| eng_rdata | input | 8 | Received byte (valid with done of a read) |
| rx_valid | output | 1 | One-cycle strobe of a received byte |
| rx_data | output | 8 | Received byte |
| scl_hold | output | 1 | Clock stretched while waiting for queue entries |
| bus_busy | output | 1 | Bus held from start until stop |
| ev_tx_err | output | 1 | Transmit-error / read-complete event pulse |
| ev_arb_lost | output | 1 | Arbitration-lost event pulse |
| ev_bus_idle | output | 1 | Bus-returned-to-idle event pulse |

## Verification
The completion of the final read byte drives two outputs from one engine handshake: the byte strobe and the transmit-error event. A fault in either register path would skew one against the other. The bench sweeps read lengths from one to four bytes and counts the cycles in which both strobes are sampled high together. It expects exactly one such cycle per read, and it also checks that the not-acknowledge request fell on the last read operation only.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } eng_op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_HELD,
    ST_LEN,
    ST_WRITE,
    ST_READ,
    ST_STOP
  } seq_state_t;

endpackage

// File: rtl/i2c_seq_rxcnt.sv
module i2c_seq_rxcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             rem_one,
  output logic             rem_two
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst)       rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (dec)  rem_q <= rem_q - ONE;
  end

  assign rem_one = (rem_q == ONE);
  assign rem_two = (rem_q == TWO);
endmodule

// File: rtl/i2c_seq_events.sv
module i2c_seq_events (
  input  logic clk,
  input  logic rst,
  input  logic set_busy,
  input  logic set_err,
  input  logic set_arb,
  input  logic set_idle,
  output logic bus_busy,
  output logic ev_tx_err,
  output logic ev_arb_lost,
  output logic ev_bus_idle
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_busy    <= 1'b0;
      ev_tx_err   <= 1'b0;
      ev_arb_lost <= 1'b0;
      ev_bus_idle <= 1'b0;
    end else begin
      ev_tx_err   <= set_err;
      ev_arb_lost <= set_arb;
      ev_bus_idle <= set_idle;
      if (set_arb || set_idle) bus_busy <= 1'b0;
      else if (set_busy)       bus_busy <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [DATA_W+1:0] cmd_data,
  output logic              cmd_pop,
  output logic              eng_req,
  output eng_op_t           eng_op,
  output logic [DATA_W-1:0] eng_wdata,
  output logic              eng_nack,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic              eng_arb_lost,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              scl_hold,
  output logic              cnt_load,
  output logic [DATA_W-1:0] cnt_val,
  output logic              cnt_dec,
  input  logic              rem_one,
  input  logic              rem_two,
  output logic              set_busy,
  output logic              set_err,
  output logic              set_arb,
  output logic              set_idle
);
  localparam int START_BIT = DATA_W;
  localparam int STOP_BIT  = DATA_W + 1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  seq_state_t st_q, st_n;
  logic [DATA_W-1:0] addr_q, addr_n;
  logic stop_q, stop_n;
  logic req_n, nk_n, rxv_n;
  eng_op_t op_n;
  logic [DATA_W-1:0] wd_n, rxd_n;

  logic go;
  eng_op_t go_op;
  logic [DATA_W-1:0] go_wd;
  logic go_nk;

  logic [DATA_W-1:0] f_byte;
  logic f_start, f_stop;
  assign f_byte  = cmd_data[DATA_W-1:0];
  assign f_start = cmd_data[START_BIT];
  assign f_stop  = cmd_data[STOP_BIT];

  always_comb begin
    st_n = st_q; addr_n = addr_q; stop_n = stop_q;
    req_n = eng_req && !eng_done;
    op_n = eng_op; wd_n = eng_wdata; nk_n = eng_nack;
    rxv_n = 1'b0; rxd_n = rx_data;
    go = 1'b0; go_op = OP_START; go_wd = '0; go_nk = 1'b0;
    cmd_pop = 1'b0; cnt_load = 1'b0; cnt_val = f_byte; cnt_dec = 1'b0;
    set_busy = 1'b0; set_err = 1'b0; set_arb = 1'b0; set_idle = 1'b0;

    unique case (st_q)
      ST_IDLE, ST_HELD: begin
        if (cmd_valid) begin
          cmd_pop = 1'b1;
          if (f_start) begin
            addr_n = f_byte; stop_n = f_stop;
            go = 1'b1; go_op = OP_START;
            st_n = ST_START;
          end else if (st_q == ST_HELD) begin
            stop_n = f_stop;
            go = 1'b1; go_op = OP_WRITE; go_wd = f_byte;
            st_n = ST_WRITE;
          end
        end
      end
      ST_START: begin
        if (eng_done) begin
          if (eng_arb_lost) begin
            set_arb = 1'b1; st_n = ST_IDLE;
          end else begin
            set_busy = 1'b1;
            go = 1'b1; go_op = OP_WRITE; go_wd = addr_q;
            st_n = ST_ADDR;
          end
        end
      end
      ST_ADDR, ST_WRITE: begin
        if (eng_done) begin
          if (eng_arb_lost) begin
            set_arb = 1'b1; st_n = ST_IDLE;
          end else if (!eng_ack) begin
            set_err = 1'b1;
            go = 1'b1; go_op = OP_STOP; st_n = ST_STOP;
          end else if (st_q == ST_ADDR && addr_q[0]) begin
            st_n = ST_LEN;
          end else if (stop_q) begin
            go = 1'b1; go_op = OP_STOP; st_n = ST_STOP;
          end else begin
            st_n = ST_HELD;
          end
        end
      end
      ST_LEN: begin
        if (cmd_valid) begin
          cmd_pop = 1'b1;
          stop_n = f_stop;
          if (f_byte == '0) begin
            if (f_stop) begin
              go = 1'b1; go_op = OP_STOP; st_n = ST_STOP;
            end else begin
              st_n = ST_HELD;
            end
          end else begin
            cnt_load = 1'b1;
            go = 1'b1; go_op = OP_READ; go_nk = (f_byte == ONE);
            st_n = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (eng_done) begin
          if (eng_arb_lost) begin
            set_arb = 1'b1; st_n = ST_IDLE;
          end else begin
            rxv_n = 1'b1; rxd_n = eng_rdata; cnt_dec = 1'b1;
            if (rem_one) begin
              set_err = 1'b1;
              if (stop_q) begin
                go = 1'b1; go_op = OP_STOP; st_n = ST_STOP;
              end else begin
                st_n = ST_HELD;
              end
            end else begin
              go = 1'b1; go_op = OP_READ; go_nk = rem_two;
            end
          end
        end
      end
      ST_STOP: begin
        if (eng_done) begin
          if (eng_arb_lost) set_arb = 1'b1;
          else              set_idle = 1'b1;
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase

    if (go) begin
      req_n = 1'b1;
      op_n  = go_op;
      if (go_op == OP_WRITE) wd_n = go_wd;
      if (go_op == OP_READ)  nk_n = go_nk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      stop_q    <= 1'b0;
      eng_req   <= 1'b0;
      eng_op    <= OP_START;
      eng_wdata <= '0;
      eng_nack  <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      st_q      <= st_n;
      addr_q    <= addr_n;
      stop_q    <= stop_n;
      eng_req   <= req_n;
      eng_op    <= op_n;
      eng_wdata <= wd_n;
      eng_nack  <= nk_n;
      rx_valid  <= rxv_n;
      rx_data   <= rxd_n;
    end
  end

  assign scl_hold = (st_q == ST_HELD || st_q == ST_LEN) && !cmd_valid;
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CMD_W  = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              cmd_pop,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [DATA_W-1:0] eng_wdata,
  output logic              eng_nack,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic              eng_arb_lost,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              scl_hold,
  output logic              bus_busy,
  output logic              ev_tx_err,
  output logic              ev_arb_lost,
  output logic              ev_bus_idle
);
  eng_op_t op_w;
  logic cnt_load, cnt_dec, rem_one, rem_two;
  logic [DATA_W-1:0] cnt_val;
  logic set_busy, set_err, set_arb, set_idle;

  assign eng_op = op_w;

  i2c_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
    .eng_req(eng_req), .eng_op(op_w), .eng_wdata(eng_wdata), .eng_nack(eng_nack),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_arb_lost(eng_arb_lost),
    .eng_rdata(eng_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .scl_hold(scl_hold),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_dec(cnt_dec),
    .rem_one(rem_one), .rem_two(rem_two),
    .set_busy(set_busy), .set_err(set_err), .set_arb(set_arb), .set_idle(set_idle)
  );

  i2c_seq_rxcnt #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst),
    .load(cnt_load), .load_val(cnt_val), .dec(cnt_dec),
    .rem_one(rem_one), .rem_two(rem_two)
  );

  i2c_seq_events u_evt (
    .clk(clk), .rst(rst),
    .set_busy(set_busy), .set_err(set_err), .set_arb(set_arb), .set_idle(set_idle),
    .bus_busy(bus_busy), .ev_tx_err(ev_tx_err),
    .ev_arb_lost(ev_arb_lost), .ev_bus_idle(ev_bus_idle)
  );
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              eng_req,
  input logic [1:0]        eng_op,
  input logic [DATA_W-1:0] eng_wdata,
  input logic              eng_nack,
  input logic              eng_done,
  input logic              eng_arb_lost,
  input logic              rx_valid,
  input logic              scl_hold,
  input logic              bus_busy,
  input logic              ev_tx_err,
  input logic              ev_arb_lost,
  input logic              ev_bus_idle
);
  // R13: request holds its operation until the engine answers
  p_req_stable_r13: assert property (@(posedge clk) disable iff (rst)
    eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_wdata));

  // R8: a completed not-acknowledged read yields byte and event together
  p_last_read_r8: assert property (@(posedge clk) disable iff (rst)
    eng_req && eng_op == 2'd3 && eng_nack && eng_done && !eng_arb_lost
    |=> rx_valid && ev_tx_err);

  // R4: bus release is always announced
  p_busy_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> ev_bus_idle || ev_arb_lost);

  // R4: idle event means the bus is released
  p_idle_free_r4: assert property (@(posedge clk) disable iff (rst)
    ev_bus_idle |-> !bus_busy);

  // R10: arbitration loss leaves the bus released
  p_arb_free_r10: assert property (@(posedge clk) disable iff (rst)
    ev_arb_lost |-> !bus_busy && !ev_bus_idle);

  // R11: stretching the clock means nothing is requested
  p_hold_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    scl_hold |-> !eng_req);
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
  .eng_nack(eng_nack), .eng_done(eng_done), .eng_arb_lost(eng_arb_lost),
  .rx_valid(rx_valid), .scl_hold(scl_hold), .bus_busy(bus_busy),
  .ev_tx_err(ev_tx_err), .ev_arb_lost(ev_arb_lost), .ev_bus_idle(ev_bus_idle)
);

// File: tb/sim_i2c_cmd_seq.sv
`timescale 1ns/1ps
module sim_i2c_cmd_seq;
  localparam int SB = 256;
  localparam int PB = 512;
  localparam int OPS = 0, OPP = 1, OPW = 2, OPR = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic cmd_valid = 1'b0;
  logic [9:0] cmd_data = '0;
  logic cmd_pop, eng_req, eng_nack, rx_valid, scl_hold, bus_busy;
  logic ev_tx_err, ev_arb_lost, ev_bus_idle;
  logic [1:0] eng_op;
  logic [7:0] eng_wdata, rx_data;
  logic eng_done = 1'b0, eng_ack = 1'b0, eng_arb_lost = 1'b0;
  logic [7:0] eng_rdata = '0;

  i2c_cmd_seq u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_nack(eng_nack),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_arb_lost(eng_arb_lost),
    .eng_rdata(eng_rdata), .rx_valid(rx_valid), .rx_data(rx_data), .scl_hold(scl_hold),
    .bus_busy(bus_busy), .ev_tx_err(ev_tx_err), .ev_arb_lost(ev_arb_lost),
    .ev_bus_idle(ev_bus_idle)
  );

  int checks = 0, errors = 0;
  int q[$];
  int lg_op[$], lg_wd[$], lg_nk[$];
  int ex_op[$], ex_wd[$], ex_nk[$];
  int rxq[$];
  int n_err, n_arb, n_idle, n_coin, n_busy_hi, n_proto, rd_idx;
  int nack_at = -1, arb_at = -1;

  // queue model: first-word-fall-through
  always @(posedge clk) begin
    if (cmd_pop && q.size() > 0) void'(q.pop_front());
    cmd_valid <= (q.size() != 0);
    cmd_data  <= (q.size() != 0) ? 10'(q[0]) : 10'd0;
  end

  // bit engine model: accepts a request, answers two cycles later
  bit e_busy = 0;
  int e_wait = 0;
  bit r_ack, r_arb;
  logic [7:0] r_rd;
  always @(posedge clk) begin
    eng_done <= 1'b0;
    eng_arb_lost <= 1'b0;
    if (rst) begin
      e_busy = 0;
    end else if (e_busy) begin
      if (e_wait == 0) begin
        eng_done <= 1'b1; eng_ack <= r_ack; eng_arb_lost <= r_arb; eng_rdata <= r_rd;
        e_busy = 0;
      end else e_wait--;
    end else if (eng_req && !eng_done) begin
      r_arb = (lg_op.size() == arb_at);
      r_ack = (lg_op.size() != nack_at);
      r_rd  = 8'(8'h30 + rd_idx);
      if (int'(eng_op) == OPR) rd_idx++;
      lg_op.push_back(int'(eng_op));
      lg_wd.push_back(int'(eng_op) == OPW ? int'(eng_wdata) : 0);
      lg_nk.push_back(int'(eng_op) == OPR ? int'(eng_nack) : 0);
      e_busy = 1; e_wait = 1;
    end
  end

  // output monitor, sampled between edges
  logic p_req = 0, p_done = 0;
  logic [1:0] p_op = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) rxq.push_back(int'(rx_data));
      if (ev_tx_err) n_err++;
      if (ev_arb_lost) n_arb++;
      if (ev_bus_idle) n_idle++;
      if (rx_valid && ev_tx_err) n_coin++;
      if (bus_busy) n_busy_hi++;
      if (cmd_pop && !cmd_valid) n_proto++;
      if (p_req && !p_done && (!eng_req || eng_op != p_op)) n_proto++;
    end
    p_req = eng_req; p_done = eng_done; p_op = eng_op;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    lg_op.delete(); lg_wd.delete(); lg_nk.delete();
    ex_op.delete(); ex_wd.delete(); ex_nk.delete(); rxq.delete();
    n_err = 0; n_arb = 0; n_idle = 0; n_coin = 0; n_busy_hi = 0; rd_idx = 0;
    nack_at = -1; arb_at = -1;
  endtask

  task automatic ex(input int op, input int wd, input int nk);
    ex_op.push_back(op); ex_wd.push_back(wd); ex_nk.push_back(nk);
  endtask

  task automatic run();
    repeat (60) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_ops(input string tag);
    int bad = -1;
    if (lg_op.size() != ex_op.size()) bad = 999;
    else foreach (ex_op[i])
      if (bad < 0 && (lg_op[i] != ex_op[i] || lg_wd[i] != ex_wd[i] || lg_nk[i] != ex_nk[i])) bad = i;
    if (bad == 999) chk(0, {tag, " op count"}, lg_op.size(), ex_op.size());
    else if (bad >= 0)
      chk(0, {tag, " op/byte/nack at index"}, lg_op[bad]*1000 + lg_wd[bad]*2 + lg_nk[bad],
          ex_op[bad]*1000 + ex_wd[bad]*2 + ex_nk[bad]);
    else chk(1, tag, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    clr(); n_proto = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(!eng_req && !bus_busy && !rx_valid && !ev_tx_err && !ev_arb_lost && !ev_bus_idle,
        "R13 reset state", int'(eng_req) + int'(bus_busy), 0);

    // R12: plain entries with the bus idle are dropped
    clr(); q.push_back(10'h055); q.push_back(10'h0AA); run();
    cmp_ops("R12 idle plain entries");
    chk(q.size() == 0, "R12 entries consumed", q.size(), 0);

    // R1 R3 R4 R5: writes of 0..3 data bytes ending in a stop
    for (int n = 0; n < 4; n++) begin
      clr();
      q.push_back(SB + 8'hA4 + (n == 0 ? PB : 0));
      for (int i = 0; i < n; i++) q.push_back(8'h10 + i + (i == n-1 ? PB : 0));
      run();
      ex(OPS, 0, 0); ex(OPW, 8'hA4, 0);
      for (int i = 0; i < n; i++) ex(OPW, 8'h10 + i, 0);
      ex(OPP, 0, 0);
      cmp_ops(n == 0 ? "R5 zero-length write" : "R3 write sequence");
      chk(n_busy_hi > 0, "R1 busy while held", n_busy_hi, 1);
      chk(n_idle == 1 && !bus_busy, "R4 idle event and release", n_idle, 1);
      chk(n_err == 0, "R3 no transmit error", n_err, 0);
    end

    // R6 R7 R8: reads of 1..4 bytes
    for (int n = 1; n <= 4; n++) begin
      clr();
      q.push_back(SB + 8'hA5); q.push_back(PB + n);
      run();
      ex(OPS, 0, 0); ex(OPW, 8'hA5, 0);
      for (int i = 0; i < n; i++) ex(OPR, 0, (i == n-1) ? 1 : 0);
      ex(OPP, 0, 0);
      cmp_ops("R7 read ack pattern");
      chk(rxq.size() == n, "R6 received byte count", rxq.size(), n);
      foreach (rxq[i]) chk(rxq[i] == 8'h30 + i, "R7 received byte", rxq[i], 8'h30 + i);
      chk(n_err == 1, "R8 one completion event", n_err, 1);
      chk(n_coin == 1, "R8 event with final byte", n_coin, 1);
      chk(n_idle == 1, "R6 stop after read", n_idle, 1);
    end

    // R2: write then repeated start into a read
    clr();
    q.push_back(SB + 8'h50); q.push_back(8'h11); q.push_back(SB + 8'h51); q.push_back(PB + 2);
    run();
    ex(OPS, 0, 0); ex(OPW, 8'h50, 0); ex(OPW, 8'h11, 0);
    ex(OPS, 0, 0); ex(OPW, 8'h51, 0); ex(OPR, 0, 0); ex(OPR, 0, 1); ex(OPP, 0, 0);
    cmp_ops("R2 repeated start");
    chk(n_idle == 1, "R2 single idle event", n_idle, 1);

    // R11: empty queue on a held bus, then while awaiting a count
    clr();
    q.push_back(SB + 8'h60); q.push_back(8'h22); run();
    chk(scl_hold && bus_busy && !eng_req, "R11 hold after data",
        int'(scl_hold)*2 + int'(eng_req), 2);
    q.push_back(SB + 8'h61); run();
    chk(scl_hold && bus_busy && !eng_req, "R11 hold awaiting count",
        int'(scl_hold)*2 + int'(eng_req), 2);
    q.push_back(PB + 2); run();
    ex(OPS, 0, 0); ex(OPW, 8'h60, 0); ex(OPW, 8'h22, 0);
    ex(OPS, 0, 0); ex(OPW, 8'h61, 0); ex(OPR, 0, 0); ex(OPR, 0, 1); ex(OPP, 0, 0);
    cmp_ops("R11 resumed sequence");
    chk(!scl_hold && !bus_busy, "R11 released", int'(scl_hold), 0);

    // R9: address not acknowledged, then recovery on next start entry
    clr(); nack_at = 1;
    q.push_back(SB + 8'h70); q.push_back(8'h01); q.push_back(PB + 8'h02);
    q.push_back(SB + PB + 8'h72);
    run();
    ex(OPS, 0, 0); ex(OPW, 8'h70, 0); ex(OPP, 0, 0);
    ex(OPS, 0, 0); ex(OPW, 8'h72, 0); ex(OPP, 0, 0);
    cmp_ops("R9 address nack and discard");
    chk(n_err == 1 && n_idle == 2, "R9 events", n_err*10 + n_idle, 12);

    // R9: data byte not acknowledged
    clr(); nack_at = 2;
    q.push_back(SB + 8'h74); q.push_back(8'h05); q.push_back(PB + 8'h06);
    run();
    ex(OPS, 0, 0); ex(OPW, 8'h74, 0); ex(OPW, 8'h05, 0); ex(OPP, 0, 0);
    cmp_ops("R9 data nack");
    chk(n_err == 1 && q.size() == 0, "R9 tail discarded", n_err*10 + q.size(), 10);

    // R10: arbitration lost on the address byte
    clr(); arb_at = 1;
    q.push_back(SB + 8'h80); q.push_back(PB + 8'h03);
    run();
    ex(OPS, 0, 0); ex(OPW, 8'h80, 0);
    cmp_ops("R10 no stop after arbitration loss");
    chk(n_arb == 1 && n_idle == 0 && !bus_busy, "R10 events",
        n_arb*10 + n_idle, 10);

    chk(n_proto == 0, "R13 handshake discipline", n_proto, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule